// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog that software configures and services through a single 32-bit control word. The word carries a down-count length, a start/stop command bit and a 7-bit key. Once a written word has started the watchdog, the block only takes a later write whose key is the bit-wise inverse of the key it holds now. Each service write therefore has to flip every key bit, and a runaway loop that keeps writing the same word cannot keep the timer alive.

Time is measured in ticks of a slow enable strobe, not in clock cycles. When the count runs out the block does not reset the system at once. It first raises a level non-maskable interrupt and reloads a short grace count, which gives a handler time to service the watchdog. If the grace count also runs out before an accepted write, the block issues a one-cycle system-reset request and stops counting. An accepted write always clears the interrupt and puts the watchdog back into its first stage.

Top module: `keyed_watchdog`

## Requirements
- R1: The control word layout is: bit 8 is the start/stop command, bits [15:9] are the 7-bit key, and bits [7:0] are the tick count. The other bits are stored but have no effect.
- R2: While the stored word has bit 8 set, a write is accepted only if its key equals the 7-bit inverse of the stored key. Any other write has no effect: the stored word, the running count, the stage and the outputs stay unchanged.
- R3: An accepted write with count N (1..255) leads to the first expiry on the N-th rising tick strobe after the write. A count of 0 means 256 ticks. Clock cycles without a tick strobe do not count.
- R4: An accepted write with bit 8 = 0 stops the counter. After it, no interrupt and no reset request appear, whatever ticks arrive.
- R5: The first expiry sets `nmiOut` high in the cycle after the expiring tick and reloads the count with GRACE_TICKS. `nmiOut` stays high as a level.
- R6: An expiry while `nmiOut` is high pulses `resetReq` high for exactly one cycle, in the cycle after the expiring tick. The counter then stops, and `nmiOut` stays high.
- R7: An accepted write clears `nmiOut` in the next cycle and returns the watchdog to its first stage. When a write and a tick arrive in the same cycle, the write wins and the tick is not counted.
- R8: Reset clears the stored word and stops the counter, and both outputs go low. The first write after reset is accepted whatever its key.
- R9: While the stored word has bit 8 clear, any write is accepted regardless of its key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Time-base strobe; one tick per high cycle |
| wrEn | input | 1 | Control-word write strobe |
| wrData | input | 32 | Control word being written |
| nmiOut | output | 1 | Non-maskable interrupt level, set by the first expiry |
| resetReq | output | 1 | One-cycle system-reset request, issued on the second expiry |

## Verification
The bench builds the block with GRACE_TICKS = 3 rather than the default of 1. This lets a check tell the grace reload apart from an immediate second expiry, and lets it see that ticks during the interrupt stage really count down. The count field is kept at its full 8 bits, so the zero-means-256 case costs only a few hundred ticks and is run in full. Writes are placed on tick cycles, on idle cycles and in the middle of a countdown. This exposes the key-inverse rule, the write-over-tick priority and the fact that a rejected write leaves the remaining count untouched.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // load count field of the written word
    logic grace;  // load grace count
    logic dec;    // count down by one
  } wdgStrobe_t;

  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_WATCH = 2'd1,
    ST_GRACE = 2'd2,
    ST_TRIP  = 2'd3
  } wdgState_e;

endpackage

// File: rtl/keyed_watchdog_datapath.sv
module keyed_watchdog_datapath
  import keyed_watchdog_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GRACE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadField,
  output logic             cntAtOne
);

  localparam int CNT_REG_W = CNT_W + 1;
  localparam logic [CNT_REG_W-1:0] FULL_VAL  = CNT_REG_W'(1) << CNT_W;
  localparam logic [CNT_REG_W-1:0] GRACE_VAL = CNT_REG_W'(GRACE_TICKS);

  logic [CNT_REG_W-1:0] cnt;
  logic [CNT_REG_W-1:0] loadVal;

  // zero in the field stands for the full range
  always_comb begin
    if (loadField == '0) loadVal = FULL_VAL;
    else                 loadVal = {1'b0, loadField};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.load)  cnt <= loadVal;
    else if (strobe.grace) cnt <= GRACE_VAL;
    else if (strobe.dec)   cnt <= cnt - 1'b1;
  end

  assign cntAtOne = (cnt == CNT_REG_W'(1));

  // R3: count never exceeds the 256-tick full range
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL_VAL);

  // R3: one tick removes exactly one from the count
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load && !strobe.grace) |=> (cnt == $past(cnt) - 1'b1));

  // R5: grace reload leaves the configured grace count
  p_grace_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grace && !strobe.load) |=> (cnt == GRACE_VAL));

endmodule

// File: rtl/keyed_watchdog_ctrl.sv
module keyed_watchdog_ctrl
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CMD_BIT = 8,
  parameter int KEY_W   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntAtOne,
  output wdgStrobe_t        strobe,
  output logic              nmiOut,
  output logic              resetReq
);

  localparam int KEY_LSB = CMD_BIT + 1;

  logic [DATA_W-1:0] storedCtrl;
  wdgState_e         state, stateNext;
  logic [KEY_W-1:0]  wrKey, storedKey;
  logic              locked, keyOk, accept, active, counting, expire;

  assign wrKey     = wrData[KEY_LSB +: KEY_W];
  assign storedKey = storedCtrl[KEY_LSB +: KEY_W];
  assign locked    = storedCtrl[CMD_BIT];
  assign keyOk     = (wrKey == ~storedKey);
  assign accept    = wrEn && (!locked || keyOk);
  assign active    = (state == ST_WATCH) || (state == ST_GRACE);
  assign counting  = active && tickEn && !accept;
  assign expire    = counting && cntAtOne;

  always_comb begin
    strobe.load  = accept;
    strobe.dec   = counting && !cntAtOne;
    strobe.grace = expire && (state == ST_WATCH);
  end

  always_comb begin
    stateNext = state;
    if (accept) begin
      stateNext = wrData[CMD_BIT] ? ST_WATCH : ST_STOP;
    end else if (expire) begin
      stateNext = (state == ST_WATCH) ? ST_GRACE : ST_TRIP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedCtrl <= '0;
      state      <= ST_STOP;
      resetReq   <= 1'b0;
    end else begin
      if (accept) storedCtrl <= wrData;
      state    <= stateNext;
      resetReq <= expire && (state == ST_GRACE);
    end
  end

  assign nmiOut = (state == ST_GRACE) || (state == ST_TRIP);

  // R2: a write with the wrong key while locked leaves the stored word alone
  p_key_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && locked && (wrKey != ~storedKey)) |=> $stable(storedCtrl));

  // R6: reset request lasts a single cycle
  p_reset_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R6: reset request only comes from the interrupt stage
  p_reset_after_nmi_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> nmiOut);

  // R7: an accepted write drops the interrupt
  p_write_drops_nmi_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !nmiOut);

  // R5: interrupt only rises after a tick
  p_nmi_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiOut) |-> $past(tickEn));

  // R4: stopped watchdog stays quiet without a write
  p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_STOP) && !wrEn) |=> (!nmiOut && !resetReq));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int CMD_BIT     = 8,
  parameter int KEY_W       = 7,
  parameter int GRACE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              nmiOut,
  output logic              resetReq
);

  wdgStrobe_t strobe;
  logic       cntAtOne;

  keyed_watchdog_ctrl #(
    .DATA_W (DATA_W),
    .CMD_BIT(CMD_BIT),
    .KEY_W  (KEY_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .cntAtOne(cntAtOne),
    .strobe  (strobe),
    .nmiOut  (nmiOut),
    .resetReq(resetReq)
  );

  keyed_watchdog_datapath #(
    .CNT_W      (CNT_W),
    .GRACE_TICKS(GRACE_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadField(wrData[CNT_W-1:0]),
    .cntAtOne (cntAtOne)
  );

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  localparam int GRACE = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        nmiOut, resetReq;

  int checks = 0;
  int errors = 0;
  string phase = "R8";
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  keyed_watchdog #(.GRACE_TICKS(GRACE)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrData(wrData), .nmiOut(nmiOut), .resetReq(resetReq)
  );

  // behavioural reference model
  logic [31:0] mCtrl;
  int          mCnt;
  bit          mRun, mNmi, mRst;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mCnt = 0; mRun = 0; mNmi = 0; mRst = 0;
    end else begin
      mRst = 0;
      if (wrEn && (!mCtrl[8] || (wrData[15:9] == (~mCtrl[15:9] & 7'h7f)))) begin
        mCtrl = wrData;
        mCnt  = (wrData[7:0] == 0) ? 256 : int'(wrData[7:0]);
        mRun  = wrData[8];
        mNmi  = 0;
      end else if (mRun && tickEn) begin
        if (mCnt == 1) begin
          if (!mNmi) begin mNmi = 1; mCnt = GRACE; end
          else begin mRst = 1; mRun = 0; end
        end else mCnt = mCnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (nmiOut !== mNmi || resetReq !== mRst) begin
        errors++;
        $display("FAIL %s model compare: nmi=%0b rst=%0b expected nmi=%0b rst=%0b",
                 phase, nmiOut, resetReq, mNmi, mRst);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [6:0] key, input logic cmd,
                                       input logic [7:0] cnt);
    return {16'h0, key, cmd, cnt};
  endfunction

  task automatic cyc(input logic t, input logic w, input logic [31:0] d);
    tickEn = t; wrEn = w; wrData = d;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, '0);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, '0);
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 reset nmi", nmiOut, 1'b0);
    chk("R8 reset rst", resetReq, 1'b0);

    // R9/R1/R3/R5/R6: unlocked write, count 5, ticks with gaps
    phase = "R3";
    cyc(1'b0, 1'b1, word(7'h15, 1'b1, 8'd5));
    ticks(4, 2);
    chk("R3 no expiry after 4 of 5 ticks", nmiOut, 1'b0);
    ticks(1, 0);
    chk("R5 nmi after 5th tick", nmiOut, 1'b1);
    phase = "R6";
    ticks(GRACE - 1, 1);
    chk("R6 no reset inside grace", resetReq, 1'b0);
    chk("R5 nmi level holds", nmiOut, 1'b1);
    cyc(1'b1, 1'b0, '0);
    chk("R6 reset request", resetReq, 1'b1);
    cyc(1'b0, 1'b0, '0);
    chk("R6 reset is one cycle", resetReq, 1'b0);
    ticks(10, 0);
    chk("R6 stopped after reset request", resetReq, 1'b0);
    chk("R6 nmi stays", nmiOut, 1'b1);

    // R2: same key again is rejected; inverse key accepted
    phase = "R2";
    cyc(1'b0, 1'b1, word(7'h15, 1'b0, 8'd3));
    chk("R2 rejected write keeps nmi", nmiOut, 1'b1);
    phase = "R7";
    cyc(1'b0, 1'b1, word(7'h6a, 1'b1, 8'd3));
    chk("R7 accepted write drops nmi", nmiOut, 1'b0);
    phase = "R2";
    ticks(1, 0);
    cyc(1'b0, 1'b1, word(7'h00, 1'b1, 8'd100));
    ticks(1, 0);
    chk("R2 count untouched by rejected write", nmiOut, 1'b0);
    ticks(1, 0);
    chk("R2 expiry at original count", nmiOut, 1'b1);

    // R7: write together with tick wins
    phase = "R7";
    cyc(1'b1, 1'b1, word(7'h15, 1'b1, 8'd2));
    chk("R7 write beats tick, nmi low", nmiOut, 1'b0);
    ticks(1, 0);
    chk("R7 tick in write cycle not counted", nmiOut, 1'b0);
    ticks(1, 0);
    chk("R7 expiry after full count", nmiOut, 1'b1);

    // R4: stop command
    phase = "R4";
    cyc(1'b0, 1'b1, word(7'h6a, 1'b0, 8'd1));
    ticks(300, 0);
    chk("R4 stopped, no nmi", nmiOut, 1'b0);
    chk("R4 stopped, no reset", resetReq, 1'b0);

    // R9 then R3 zero count
    phase = "R9";
    cyc(1'b0, 1'b1, word(7'h00, 1'b1, 8'd0));
    phase = "R3";
    ticks(255, 0);
    chk("R3 zero count not expired at 255", nmiOut, 1'b0);
    ticks(1, 0);
    chk("R3 zero count expires at 256", nmiOut, 1'b1);

    // R8: mid-run reset clears stored key
    phase = "R8";
    rstN = 1'b0;
    @(negedge clk);
    chk("R8 nmi cleared by reset", nmiOut, 1'b0);
    chk("R8 reset request low in reset", resetReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    ticks(20, 0);
    chk("R8 counter stopped after reset", nmiOut, 1'b0);
    cyc(1'b0, 1'b1, word(7'h33, 1'b1, 8'd2));
    ticks(2, 0);
    chk("R8 any key accepted after reset", nmiOut, 1'b1);

    // R1: upper bits stored but inert
    phase = "R1";
    cyc(1'b0, 1'b1, 32'hFFFF_0000 | word(7'h4c, 1'b1, 8'd1));
    chk("R1 upper bits ignored, nmi low", nmiOut, 1'b0);
    ticks(1, 0);
    chk("R1 count field in low byte", nmiOut, 1'b1);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule